// File: doc/BRIEF.md
# Byte/Word Bus Width Adapter

This block connects a 16-bit host data path to a memory port that runs either as a byte-wide or a word-wide device, chosen by a mode input. The host always presents a byte address, a direction, a command flag and a 16-bit write word. The adapter turns each request into one registered memory access and returns the read result one cycle later.

In word mode all sixteen data lines carry data, and the lowest host address bit is dropped. In byte mode the most significant data line becomes an extra low-order address output that picks the byte within the addressed word. Lines 8 to 14 are released, and the selected byte travels on the low lane. Command writes use only the low lane in either mode. Status reads return only their low byte. Lane release is modelled with per-group output-enable signals: low lane (bits 7:0), middle group (bits 14:8) and top line (bit 15).

Top module: `bwa_top`

## Requirements
- R1: After reset, and in every cycle without an access, the chip-select and write strobes and all three output enables are 0, and busy and done are 0.
- R2: A word-mode data write drives all sixteen lines with the host word, and all three enables are 1.
- R3: A read drives neither the low lane nor the middle group. A word-mode data read returns all sixteen memory lines on the host read data.
- R4: In byte mode the top line is enabled and carries host address bit 0, where 0 selects the low byte (bits 7:0) and 1 selects the high byte (bits 15:8). The memory word address is host address bits above bit 0.
- R5: In byte mode the middle group (bits 14:8) is never enabled.
- R6: A byte-mode write drives host write bits 7:0 on the low lane, and only the selected byte of the word changes.
- R7: A byte-mode read returns memory lines 7:0 on host bits 7:0, and host bits 15:8 are zero.
- R8: A command write drives host bits 7:0 on the low lane only. In word mode the middle group and top line stay disabled, so the upper byte of the word is untouched.
- R9: A status read (command flag set, read direction) returns memory lines 7:0 with host bits 15:8 zero, in both modes.
- R10: In word mode host address bit 0 has no effect: an odd and an even address reach the same word.
- R11: The mode input is sampled only when a request is accepted. A change during an access does not alter that access or the mode output.
- R12: A request is accepted when busy is 0. The memory strobes are active in the following cycle, and done pulses for exactly one cycle one cycle after that. A request raised while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_mode_i | input | 1 | 1 = word (x16) port, 0 = byte (x8) port |
| req_i | input | 1 | Request strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| cmd_i | input | 1 | Command write / status read flag |
| addr_i | input | ADDR_W | Host byte address |
| wdata_i | input | DATA_W | Host write word |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Read result |
| mem_cs_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wide_o | output | 1 | Latched mode driven to the memory |
| mem_addr_o | output | ADDR_W-1 | Memory word address |
| mem_dq_o | output | DATA_W | Outgoing data lines; bit 15 is the byte select in byte mode |
| mem_lo_oe_o | output | 1 | Drive enable, bits 7:0 |
| mem_mid_oe_o | output | 1 | Drive enable, bits 14:8 |
| mem_top_oe_o | output | 1 | Drive enable, bit 15 |
| mem_dq_i | input | DATA_W | Incoming data lines |

## Verification
The bench builds the adapter with ADDR_W = 6 and the default 16-bit data width. The memory behind it then holds only 32 words, so random traffic lands on the same words often. Byte writes, command writes and word writes thus overlap with later reads in both modes, and partial-lane updates show up in the read-back. The behavioural memory places a fixed non-zero pattern on lines 15:8 during byte-mode reads, so a missing zero fill is visible.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_ACCESS} bwa_state_e;

  typedef struct packed {
    logic lo;
    logic mid;
    logic top;
  } lane_oe_t;
endpackage

// File: rtl/bwa_drive_map.sv
module bwa_drive_map
  import bwa_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              wide_i,
  input  logic              wr_i,
  input  logic              cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-2:0] word_addr_o,
  output logic [DATA_W-1:0] dq_o,
  output lane_oe_t          oe_o
);
  localparam int LANE_W = DATA_W / 2;

  always_comb begin
    word_addr_o = addr_i[ADDR_W-1:1];
    dq_o        = '0;
    oe_o        = '0;
    if (wide_i) begin
      if (wr_i) begin
        oe_o.lo = 1'b1;
        if (cmd_i) begin
          dq_o[LANE_W-1:0] = wdata_i[LANE_W-1:0];
        end else begin
          dq_o     = wdata_i;
          oe_o.mid = 1'b1;
          oe_o.top = 1'b1;
        end
      end
    end else begin
      oe_o.top         = 1'b1;
      dq_o[DATA_W-1]   = addr_i[0];
      if (wr_i) begin
        oe_o.lo          = 1'b1;
        dq_o[LANE_W-1:0] = wdata_i[LANE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/bwa_read_steer.sv
module bwa_read_steer #(
  parameter int DATA_W = 16
) (
  input  logic              wide_i,
  input  logic              status_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int LANE_W = DATA_W / 2;

  always_comb begin
    if (wide_i && !status_i) begin
      rdata_o = dq_i;
    end else begin
      rdata_o = {{(DATA_W-LANE_W){1'b0}}, dq_i[LANE_W-1:0]};
    end
  end
endmodule

// File: rtl/bwa_top.sv
module bwa_top
  import bwa_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_mode_i,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic              cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_cs_o,
  output logic              mem_we_o,
  output logic              mem_wide_o,
  output logic [ADDR_W-2:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_lo_oe_o,
  output logic              mem_mid_oe_o,
  output logic              mem_top_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int LANE_W = DATA_W / 2;

  bwa_state_e        state;
  logic              we_q, cmd_q, status_q;
  logic [ADDR_W-2:0] map_addr;
  logic [DATA_W-1:0] map_dq;
  lane_oe_t          map_oe;
  logic [DATA_W-1:0] steer_data;

  bwa_drive_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_map (
    .wide_i(word_mode_i), .wr_i(wr_i), .cmd_i(cmd_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .word_addr_o(map_addr), .dq_o(map_dq), .oe_o(map_oe)
  );

  bwa_read_steer #(.DATA_W(DATA_W)) u_steer (
    .wide_i(mem_wide_o), .status_i(status_q), .dq_i(mem_dq_i), .rdata_o(steer_data)
  );

  assign busy_o = (state == ST_ACCESS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      done_o       <= 1'b0;
      rdata_o      <= '0;
      mem_cs_o     <= 1'b0;
      mem_we_o     <= 1'b0;
      mem_wide_o   <= 1'b0;
      mem_addr_o   <= '0;
      mem_dq_o     <= '0;
      mem_lo_oe_o  <= 1'b0;
      mem_mid_oe_o <= 1'b0;
      mem_top_oe_o <= 1'b0;
      we_q         <= 1'b0;
      cmd_q        <= 1'b0;
      status_q     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_i) begin
            state        <= ST_ACCESS;
            mem_cs_o     <= 1'b1;
            mem_we_o     <= wr_i;
            mem_wide_o   <= word_mode_i;
            mem_addr_o   <= map_addr;
            mem_dq_o     <= map_dq;
            mem_lo_oe_o  <= map_oe.lo;
            mem_mid_oe_o <= map_oe.mid;
            mem_top_oe_o <= map_oe.top;
            we_q         <= wr_i;
            cmd_q        <= cmd_i;
            status_q     <= cmd_i && !wr_i;
          end
        end
        ST_ACCESS: begin
          state        <= ST_IDLE;
          done_o       <= 1'b1;
          if (!we_q) rdata_o <= steer_data;
          mem_cs_o     <= 1'b0;
          mem_we_o     <= 1'b0;
          mem_dq_o     <= '0;
          mem_lo_oe_o  <= 1'b0;
          mem_mid_oe_o <= 1'b0;
          mem_top_oe_o <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_o |-> !(mem_lo_oe_o || mem_mid_oe_o || mem_top_oe_o || mem_we_o)); // R1
  AST_READ_NOT_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    mem_cs_o && !mem_we_o |-> !mem_lo_oe_o && !mem_mid_oe_o); // R3
  AST_X8_TOP_ADDR: assert property (@(posedge clk) disable iff (rst)
    mem_cs_o && !mem_wide_o |-> mem_top_oe_o); // R4
  AST_X8_MID_RELEASED: assert property (@(posedge clk) disable iff (rst)
    mem_cs_o && !mem_wide_o |-> !mem_mid_oe_o); // R5
  AST_CMD_UPPER_QUIET: assert property (@(posedge clk) disable iff (rst)
    mem_cs_o && mem_we_o && cmd_q && mem_wide_o |-> !mem_mid_oe_o && !mem_top_oe_o); // R8
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    done_o && !we_q && (!mem_wide_o || status_q) |-> rdata_o[DATA_W-1:LANE_W] == '0); // R7
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> $stable(mem_wide_o)); // R11
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    req_i && !busy_o |=> busy_o && mem_cs_o); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R12
endmodule

// File: tb/test_bwa_top.sv
module test_bwa_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int NW = 2 ** (AW - 1);

  logic clk = 1'b0, rst = 1'b1;
  logic word_mode_i = 1'b1, req_i = 1'b0, wr_i = 1'b0, cmd_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic busy_o, done_o, mem_cs_o, mem_we_o, mem_wide_o;
  logic mem_lo_oe_o, mem_mid_oe_o, mem_top_oe_o;
  logic [DW-1:0] rdata_o, mem_dq_o, mem_dq_i;
  logic [AW-2:0] mem_addr_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [DW-1:0] mem [NW];
  logic [DW-1:0] shadow [NW];

  bwa_top #(.ADDR_W(AW), .DATA_W(DW)) i_bwa_top (
    .clk(clk), .rst(rst), .word_mode_i(word_mode_i), .req_i(req_i), .wr_i(wr_i),
    .cmd_i(cmd_i), .addr_i(addr_i), .wdata_i(wdata_i), .busy_o(busy_o),
    .done_o(done_o), .rdata_o(rdata_o), .mem_cs_o(mem_cs_o), .mem_we_o(mem_we_o),
    .mem_wide_o(mem_wide_o), .mem_addr_o(mem_addr_o), .mem_dq_o(mem_dq_o),
    .mem_lo_oe_o(mem_lo_oe_o), .mem_mid_oe_o(mem_mid_oe_o),
    .mem_top_oe_o(mem_top_oe_o), .mem_dq_i(mem_dq_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural memory: byte mode uses line 15 as byte select
  always @(posedge clk) begin
    if (mem_cs_o && mem_we_o) begin
      if (mem_wide_o) begin
        if (mem_lo_oe_o)  mem[mem_addr_o][7:0]  <= mem_dq_o[7:0];
        if (mem_mid_oe_o) mem[mem_addr_o][14:8] <= mem_dq_o[14:8];
        if (mem_top_oe_o) mem[mem_addr_o][15]   <= mem_dq_o[15];
      end else if (mem_lo_oe_o) begin
        if (mem_dq_o[15]) mem[mem_addr_o][15:8] <= mem_dq_o[7:0];
        else              mem[mem_addr_o][7:0]  <= mem_dq_o[7:0];
      end
    end
  end

  always_comb begin
    mem_dq_i = 16'h5A5A;
    if (mem_cs_o && !mem_we_o) begin
      if (mem_wide_o) mem_dq_i = mem[mem_addr_o];
      else mem_dq_i = {8'hC3, mem_dq_o[15] ? mem[mem_addr_o][15:8] : mem[mem_addr_o][7:0]};
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_read(input logic wide, input logic cmd, input logic [AW-1:0] a);
    logic [DW-1:0] w = shadow[a[AW-1:1]];
    if (wide && !cmd) return w;
    if (wide) return {8'h00, w[7:0]};
    return {8'h00, a[0] ? w[15:8] : w[7:0]};
  endfunction

  task automatic upd_write(input logic wide, input logic cmd, input logic [AW-1:0] a, input logic [DW-1:0] d);
    if (wide && !cmd) shadow[a[AW-1:1]] = d;
    else if (wide) shadow[a[AW-1:1]][7:0] = d[7:0];
    else if (a[0]) shadow[a[AW-1:1]][15:8] = d[7:0];
    else shadow[a[AW-1:1]][7:0] = d[7:0];
  endtask

  task automatic txn(input logic wide, input logic wr, input logic cmd,
                     input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    word_mode_i = wide; req_i = 1'b1; wr_i = wr; cmd_i = cmd; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0;
    chk("R12 strobe in access cycle", {14'd0, mem_cs_o, busy_o}, 16'h0003);
    chk("R4 word address", {11'd0, mem_addr_o}, {11'd0, a[AW-1:1]});
    chk("R11 latched mode", {15'd0, mem_wide_o}, {15'd0, wide});
    chk("R3/R5/R8 lane enables", {13'd0, mem_lo_oe_o, mem_mid_oe_o, mem_top_oe_o},
        {13'd0, wr, wide && wr && !cmd, !wide || (wr && !cmd)});
    if (!wide) chk("R4 top line is byte select", {15'd0, mem_dq_o[15]}, {15'd0, a[0]});
    if (wr) chk("R6/R8 low lane data", {8'd0, mem_dq_o[7:0]}, {8'd0, d[7:0]});
    if (wide && wr && !cmd) chk("R2 full word driven", mem_dq_o, d);
    @(negedge clk);
    chk("R12 done pulse", {15'd0, done_o}, 16'h0001);
    if (!wr) begin
      if (cmd) chk("R9 status read", rdata_o, exp_read(wide, cmd, a));
      else if (wide) chk("R3/R10 word read", rdata_o, exp_read(wide, cmd, a));
      else chk("R7 byte read", rdata_o, exp_read(wide, cmd, a));
    end else begin
      upd_write(wide, cmd, a, d);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < NW; i++) begin
      mem[i] = 16'(i * 16'h1357 + 16'h2468);
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset",
        {10'd0, mem_cs_o, mem_we_o, mem_lo_oe_o, mem_mid_oe_o, mem_top_oe_o, busy_o | done_o},
        16'h0000);

    // directed corners
    txn(1, 1, 0, 6'd4, 16'hBEEF);        // R2 word write
    txn(1, 0, 0, 6'd5, 16'h0000);        // R10 odd address reaches same word
    txn(0, 1, 0, 6'd5, 16'hFF12);        // R6 high byte write
    txn(0, 0, 0, 6'd5, 16'h0000);        // R7 read high byte
    txn(0, 0, 0, 6'd4, 16'h0000);        // R7 read low byte
    txn(1, 1, 1, 6'd8, 16'hAB55);        // R8 command write in word mode
    txn(1, 0, 0, 6'd8, 16'h0000);        // R8 upper byte untouched
    txn(1, 0, 1, 6'd8, 16'h0000);        // R9 status read, word mode
    txn(0, 0, 1, 6'd9, 16'h0000);        // R9 status read, byte mode

    // R11: mode flips during an access
    @(negedge clk);
    word_mode_i = 1'b0; req_i = 1'b1; wr_i = 1'b0; cmd_i = 1'b0; addr_i = 6'd11;
    @(negedge clk);
    req_i = 1'b0; word_mode_i = 1'b1;
    chk("R11 mode held in access", {15'd0, mem_wide_o}, 16'h0000);
    @(negedge clk);
    chk("R11 byte result despite flip", rdata_o, exp_read(0, 0, 6'd11));
    chk("R11 mode output held", {15'd0, mem_wide_o}, 16'h0000);

    // R12: request while busy is dropped
    @(negedge clk);
    word_mode_i = 1'b1; req_i = 1'b1; wr_i = 1'b0; cmd_i = 1'b0; addr_i = 6'd12;
    @(negedge clk);
    req_i = 1'b1; wr_i = 1'b1; addr_i = 6'd14; wdata_i = 16'h1111;
    chk("R12 busy in access", {15'd0, busy_o}, 16'h0001);
    @(negedge clk);
    req_i = 1'b0;
    chk("R12 done once", {15'd0, done_o}, 16'h0001);
    @(negedge clk);
    chk("R12 no second access", {14'd0, done_o, busy_o}, 16'h0000);
    txn(1, 0, 0, 6'd14, 16'h0000);       // R12 word 7 unchanged

    // random traffic
    for (int n = 0; n < 400; n++) begin
      logic wide, wr, cmd;
      wide = 1'($urandom);
      wr = 1'($urandom);
      cmd = (($urandom % 4) == 0);
      txn(wide, wr, cmd, AW'($urandom), DW'($urandom));
    end

    @(negedge clk);
    chk("R1 idle at end", {14'd0, mem_cs_o, busy_o}, 16'h0000);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule